// File: doc/BRIEF.md
# Table-Driven GEMM Operand Sequencer

This block drives a matrix-multiply array without any instruction stream. Before a run, the host fills a small table. Each row of the table describes one sub-GEMM, which is one piece of a larger multiplication that the host has already cut up. A row holds four things: the memory address of the operand that stays fixed in the array, the address and beat count of the operand that streams through it, the address the result goes back to, and a layer number.

After a start pulse the block walks the rows in order. For each row it asks the memory side for a burst that loads the fixed operand, then for a burst that carries the streaming operand. The order in which operands arrive is the only thing that sets the order of computation.

When the array reports that a sub-GEMM's result is ready, it gives the table index of that sub-GEMM. The block looks up the matching row and issues a write-back to that row's result address. A count of sub-GEMMs that have been issued but not yet written back enforces the dependency between layers. A row from a new layer is held until that count reaches zero. Rows that share a layer issue back to back without waiting.

Top module: `gemm_table_sequencer`

## Requirements
- R1: After reset, `rdValid`, `wrValid` and `done` are low, and no request is issued until `start` is seen.
- R2: A `start` pulse while idle or done begins the walk at row 0. A `start` seen while a walk is in progress has no effect.
- R3: For each row, the first read request has `rdKind`=0 (fixed operand), `rdAddr` equal to the row's fixed-operand address, `rdLen` equal to the parameter STAT_BEATS, and `rdTag` equal to the row index.
- R4: Once the fixed-operand request is accepted, the next request is for the same row with `rdKind`=1, `rdAddr` equal to the streaming address, and `rdLen` equal to the row's streaming length.
- R5: A request is accepted on a cycle where `rdValid` and `rdReady` are both high. Until then `rdValid` stays high and the address, length, kind and tag stay unchanged.
- R6: Rows are requested in increasing index order, from 0 up to `lastIdx` inclusive. `lastIdx` is held stable during a walk.
- R7: A cycle with `resValid` high and `resTag`=i is followed, one cycle later, by `wrValid` high with `wrTag`=i and `wrAddr` equal to row i's result address. A write-back never occurs without a preceding result.
- R8: The fixed-operand request of a row whose layer differs from the layer currently running is not issued until every sub-GEMM issued so far has been written back.
- R9: `done` rises once the last row has been issued and all of its write-backs have occurred. It then stays high until the next accepted `start`.
- R10: Rows that share the current layer are requested without waiting for earlier write-backs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Host table write strobe |
| cfgIdx | input | IDXW | Table row being written |
| cfgStatAddr | input | AW | Fixed-operand address for the row |
| cfgStrmAddr | input | AW | Streaming-operand address for the row |
| cfgStrmLen | input | LW | Streaming-operand beat count |
| cfgResAddr | input | AW | Result write-back address |
| cfgLayer | input | LYW | Layer number of the row |
| start | input | 1 | Begin a walk at row 0 |
| lastIdx | input | IDXW | Index of the final row of the walk |
| rdValid | output | 1 | Burst-read request valid |
| rdReady | input | 1 | Memory side accepts the request |
| rdAddr | output | AW | Burst start address |
| rdLen | output | LW | Burst length in beats |
| rdKind | output | 1 | 0 = fixed operand, 1 = streaming operand |
| rdTag | output | IDXW | Table row of the request |
| resValid | input | 1 | Array reports a finished result |
| resTag | input | IDXW | Table row of the finished result |
| wrValid | output | 1 | Write-back request |
| wrAddr | output | AW | Write-back address |
| wrTag | output | IDXW | Table row being written back |
| done | output | 1 | Walk complete with all results written back |

## Verification
If the outstanding count drifts too high, the walk stalls before the first row of a new layer, or `done` never rises. If it drifts too low, a new layer's fixed-operand read appears while a write-back is still pending. Either fault shows at the ports within one row of the layer boundary. A wrong row index or a wrong field selection shows up as a read or write-back address that differs from the table on the very cycle the request is presented. The bench predicts every port on every cycle, so the first divergent cycle is the one reported.

// File: rtl/gemm_seq_pkg.sv
package gemm_seq_pkg;

  // Walk phases of the sequencer control.
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_FETCH,
    SEQ_STAT,
    SEQ_STRM,
    SEQ_DRAIN,
    SEQ_DONE
  } seqState_t;

  // Strobes from the control to the table datapath.
  typedef struct packed {
    logic rdOn;     // a read request is being presented
    logic selStrm;  // present the streaming operand rather than the fixed one
  } seqStrobe_t;

endpackage

// File: rtl/gemm_seq_table.sv
module gemm_seq_table
  import gemm_seq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int AW         = 32,
  parameter int LW         = 8,
  parameter int LYW        = 4,
  parameter int STAT_BEATS = 32,
  localparam int IDXW      = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [IDXW-1:0] cfgIdx,
  input  logic [AW-1:0]   cfgStatAddr,
  input  logic [AW-1:0]   cfgStrmAddr,
  input  logic [LW-1:0]   cfgStrmLen,
  input  logic [AW-1:0]   cfgResAddr,
  input  logic [LYW-1:0]  cfgLayer,
  input  seqStrobe_t      strobe,
  input  logic [IDXW-1:0] curIdx,
  input  logic            resValid,
  input  logic [IDXW-1:0] resTag,
  output logic [AW-1:0]   rdAddr,
  output logic [LW-1:0]   rdLen,
  output logic            rdKind,
  output logic [LYW-1:0]  entryLayer,
  output logic            wrValid,
  output logic [AW-1:0]   wrAddr,
  output logic [IDXW-1:0] wrTag
);

  localparam logic [LW-1:0] STAT_LEN = LW'(STAT_BEATS);

  logic [AW-1:0]  statMem  [DEPTH];
  logic [AW-1:0]  strmMem  [DEPTH];
  logic [LW-1:0]  lenMem   [DEPTH];
  logic [AW-1:0]  resMem   [DEPTH];
  logic [LYW-1:0] layerMem [DEPTH];

  // Host programming of one row per strobe.
  always_ff @(posedge clk) begin
    if (cfgWe) begin
      statMem[cfgIdx]  <= cfgStatAddr;
      strmMem[cfgIdx]  <= cfgStrmAddr;
      lenMem[cfgIdx]   <= cfgStrmLen;
      resMem[cfgIdx]   <= cfgResAddr;
      layerMem[cfgIdx] <= cfgLayer;
    end
  end

  // Request fields for the row under the walk pointer.
  always_comb begin
    rdKind     = strobe.selStrm;
    entryLayer = layerMem[curIdx];
    if (!strobe.rdOn) begin
      rdAddr = '0;
      rdLen  = '0;
    end else if (strobe.selStrm) begin
      rdAddr = strmMem[curIdx];
      rdLen  = lenMem[curIdx];
    end else begin
      rdAddr = statMem[curIdx];
      rdLen  = STAT_LEN;
    end
  end

  // Result routing: the returned tag selects its write-back address.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrTag   <= '0;
    end else begin
      wrValid <= resValid;
      if (resValid) begin
        wrAddr <= resMem[resTag];
        wrTag  <= resTag;
      end
    end
  end

  assert_wb_follows_result_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> $past(resValid));

endmodule

// File: rtl/gemm_seq_ctrl.sv
module gemm_seq_ctrl
  import gemm_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LYW   = 4,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [IDXW-1:0] lastIdx,
  input  logic            rdReady,
  input  logic [LYW-1:0]  entryLayer,
  input  logic            wrFire,
  output logic            rdValid,
  output seqStrobe_t      strobe,
  output logic [IDXW-1:0] curIdx,
  output logic            done
);

  seqState_t       state;
  logic [LYW-1:0]  curLayer;
  logic [CNTW-1:0] pend;
  logic            issueInc;
  logic            layerOk;

  assign rdValid        = (state == SEQ_STAT) || (state == SEQ_STRM);
  assign strobe.rdOn    = rdValid;
  assign strobe.selStrm = (state == SEQ_STRM);
  assign done           = (state == SEQ_DONE);
  assign issueInc       = (state == SEQ_STRM) && rdReady;
  assign layerOk        = (entryLayer == curLayer) || (pend == '0);

  // Outstanding sub-GEMMs of the running layer.
  always_ff @(posedge clk) begin
    if (!rstN) pend <= '0;
    else       pend <= pend + CNTW'(issueInc) - CNTW'(wrFire);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      curIdx   <= '0;
      curLayer <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE, SEQ_DONE: if (start) begin
          curIdx <= '0;
          state  <= SEQ_FETCH;
        end
        SEQ_FETCH: if (layerOk) begin
          curLayer <= entryLayer;
          state    <= SEQ_STAT;
        end
        SEQ_STAT: if (rdReady) state <= SEQ_STRM;
        SEQ_STRM: if (rdReady) begin
          if (curIdx == lastIdx) state <= SEQ_DRAIN;
          else begin
            curIdx <= curIdx + 1'b1;
            state  <= SEQ_FETCH;
          end
        end
        SEQ_DRAIN: if (pend == '0) state <= SEQ_DONE;
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrFire |-> (pend != '0));

  assert_layer_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_FETCH && entryLayer != curLayer && pend != '0) |=> (state == SEQ_FETCH));

  assert_done_drained_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pend == '0));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    issueInc |-> (pend < CNTW'(DEPTH)));

endmodule

// File: rtl/gemm_table_sequencer.sv
module gemm_table_sequencer
  import gemm_seq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int AW         = 32,
  parameter int LW         = 8,
  parameter int LYW        = 4,
  parameter int STAT_BEATS = 32,
  localparam int IDXW      = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [IDXW-1:0] cfgIdx,
  input  logic [AW-1:0]   cfgStatAddr,
  input  logic [AW-1:0]   cfgStrmAddr,
  input  logic [LW-1:0]   cfgStrmLen,
  input  logic [AW-1:0]   cfgResAddr,
  input  logic [LYW-1:0]  cfgLayer,
  input  logic            start,
  input  logic [IDXW-1:0] lastIdx,
  output logic            rdValid,
  input  logic            rdReady,
  output logic [AW-1:0]   rdAddr,
  output logic [LW-1:0]   rdLen,
  output logic            rdKind,
  output logic [IDXW-1:0] rdTag,
  input  logic            resValid,
  input  logic [IDXW-1:0] resTag,
  output logic            wrValid,
  output logic [AW-1:0]   wrAddr,
  output logic [IDXW-1:0] wrTag,
  output logic            done
);

  seqStrobe_t      strobe;
  logic [IDXW-1:0] curIdx;
  logic [LYW-1:0]  entryLayer;

  gemm_seq_ctrl #(.DEPTH(DEPTH), .LYW(LYW)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .lastIdx(lastIdx),
    .rdReady(rdReady), .entryLayer(entryLayer), .wrFire(wrValid),
    .rdValid(rdValid), .strobe(strobe), .curIdx(curIdx), .done(done)
  );

  gemm_seq_table #(.DEPTH(DEPTH), .AW(AW), .LW(LW), .LYW(LYW),
                   .STAT_BEATS(STAT_BEATS)) uTable (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgStatAddr(cfgStatAddr), .cfgStrmAddr(cfgStrmAddr),
    .cfgStrmLen(cfgStrmLen), .cfgResAddr(cfgResAddr), .cfgLayer(cfgLayer),
    .strobe(strobe), .curIdx(curIdx), .resValid(resValid), .resTag(resTag),
    .rdAddr(rdAddr), .rdLen(rdLen), .rdKind(rdKind), .entryLayer(entryLayer),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrTag(wrTag)
  );

  assign rdTag = curIdx;

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdAddr) && $stable(rdLen)
                               && $stable(rdKind) && $stable(rdTag)));

  assert_stat_then_strm_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdReady && !rdKind) |=> (rdValid && rdKind && $stable(rdTag)));

endmodule

// File: tb/tb_gemm_table_sequencer.sv
module tb_gemm_table_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = 32;
  localparam int LW = 8;
  localparam int LYW = 4;
  localparam int STAT_BEATS = 32;
  localparam int IDXW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [IDXW-1:0] cfgIdx = '0;
  logic [AW-1:0] cfgStatAddr = '0, cfgStrmAddr = '0, cfgResAddr = '0;
  logic [LW-1:0] cfgStrmLen = '0;
  logic [LYW-1:0] cfgLayer = '0;
  logic start = 1'b0;
  logic [IDXW-1:0] lastIdx = '0;
  logic rdValid, rdReady = 1'b0, rdKind, wrValid, done;
  logic [AW-1:0] rdAddr, wrAddr;
  logic [LW-1:0] rdLen;
  logic [IDXW-1:0] rdTag, wrTag;
  logic resValid = 1'b0;
  logic [IDXW-1:0] resTag = '0;

  gemm_table_sequencer #(.DEPTH(DEPTH), .AW(AW), .LW(LW), .LYW(LYW),
                         .STAT_BEATS(STAT_BEATS)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int tStat[DEPTH], tStrm[DEPTH], tLen[DEPTH], tRes[DEPTH], tLay[DEPTH];
  // reference model state
  int mPhase = 0, mIdx = 0, mLayer = 0, mPend = 0, mWrTag = 0, mWrAddr = 0, nPend = 0;
  bit mWrValid = 0;
  // array emulation and observation
  int qTag[$], qDue[$];
  int readyMode = 0, latMax = 3, outstanding = 0, expNextTag = 0, prevLayer = -1;
  bit sawOverlap = 0, running = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  // Behavioural reference of port activity.
  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mIdx = 0; mLayer = 0; mPend = 0; mWrValid = 0;
    end else begin
      nPend = mPend + ((mPhase == 3 && rdReady) ? 1 : 0) - (mWrValid ? 1 : 0);
      case (mPhase)
        0, 5: if (start) begin mIdx = 0; mPhase = 1; end
        1: if (tLay[mIdx] == mLayer || mPend == 0) begin mLayer = tLay[mIdx]; mPhase = 2; end
        2: if (rdReady) mPhase = 3;
        3: if (rdReady) begin
             if (mIdx == int'(lastIdx)) mPhase = 4;
             else begin mIdx++; mPhase = 1; end
           end
        4: if (mPend == 0) mPhase = 5;
        default: mPhase = 0;
      endcase
      mPend = nPend;
      mWrValid = resValid;
      if (resValid) begin mWrTag = int'(resTag); mWrAddr = tRes[resTag]; end
    end
  end

  // Per-cycle comparison, memory-side and array-side emulation.
  always @(negedge clk) begin
    if (rstN) begin
      bit expRv;
      expRv = (mPhase == 2 || mPhase == 3);
      chk(rdValid == expRv, "R5/R8 rdValid", int'(rdValid), int'(expRv));
      if (rdValid && expRv) begin
        chk(rdTag == IDXW'(mIdx), "R6 rdTag", int'(rdTag), mIdx);
        if (mPhase == 2) begin
          chk(rdKind == 1'b0, "R3 rdKind", int'(rdKind), 0);
          chk(rdAddr == AW'(tStat[mIdx]), "R3 rdAddr", int'(rdAddr), tStat[mIdx]);
          chk(rdLen == LW'(STAT_BEATS), "R3 rdLen", int'(rdLen), STAT_BEATS);
        end else begin
          chk(rdKind == 1'b1, "R4 rdKind", int'(rdKind), 1);
          chk(rdAddr == AW'(tStrm[mIdx]), "R4 rdAddr", int'(rdAddr), tStrm[mIdx]);
          chk(rdLen == LW'(tLen[mIdx]), "R4 rdLen", int'(rdLen), tLen[mIdx]);
        end
      end
      chk(wrValid == mWrValid, "R7 wrValid", int'(wrValid), int'(mWrValid));
      if (wrValid && mWrValid) begin
        chk(wrTag == IDXW'(mWrTag), "R7 wrTag", int'(wrTag), mWrTag);
        chk(wrAddr == AW'(mWrAddr), "R7 wrAddr", int'(wrAddr), mWrAddr);
        outstanding--;
      end
      chk(done == (mPhase == 5), "R9 done", int'(done), int'(mPhase == 5));
    end
    case (readyMode)
      0: rdReady = 1'b1;
      1: rdReady = (cyc % 3) != 0;
      default: rdReady = (cyc % 5) < 2;
    endcase
    if (rstN && rdValid && rdReady) begin
      if (!rdKind) begin
        chk(int'(rdTag) == expNextTag, "R6 row order", int'(rdTag), expNextTag);
        if (prevLayer >= 0 && tLay[rdTag] != prevLayer)
          chk(outstanding == 0, "R8 layer waits for write-back", outstanding, 0);
        else if (outstanding > 0) sawOverlap = 1;
        prevLayer = tLay[rdTag];
        expNextTag = int'(rdTag) + 1;
      end else begin
        qTag.push_back(int'(rdTag));
        qDue.push_back(cyc + 1 + ((cyc * 7) % latMax));
        outstanding++;
      end
    end
    resValid = 1'b0;
    if (qDue.size() > 0 && qDue[0] <= cyc) begin
      resValid = 1'b1;
      resTag = IDXW'(qTag.pop_front());
      void'(qDue.pop_front());
    end
  end

  task automatic prog(input int i, input int lay);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = IDXW'(i);
    tStat[i] = 32'h1000 + i * 64;  tStrm[i] = 32'h8000 + i * 96;
    tLen[i]  = 5 + i * 3;          tRes[i]  = 32'h20000 + i * 16;
    tLay[i]  = lay;
    cfgStatAddr = AW'(tStat[i]); cfgStrmAddr = AW'(tStrm[i]);
    cfgStrmLen = LW'(tLen[i]); cfgResAddr = AW'(tRes[i]); cfgLayer = LYW'(lay);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic runWalk(input int last, input bit midStart);
    int waited;
    lastIdx = IDXW'(last);
    expNextTag = 0; prevLayer = -1; sawOverlap = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    waited = 0;
    while (!done && waited < 5000) begin
      @(negedge clk); waited++;
      if (midStart && waited == 9) start = 1'b1;   // R2: ignored while busy
      else start = 1'b0;
    end
    start = 1'b0;
    chk(waited < 5000, "R9 walk completes", waited, 5000);
    chk(expNextTag == last + 1, "R6 all rows issued", expNextTag, last + 1);
    repeat (6) @(negedge clk);
    chk(done == 1'b1, "R9 done held", int'(done), 1);
    chk(outstanding == 0, "R9 all written back", outstanding, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rdValid == 1'b0 && wrValid == 1'b0 && done == 1'b0, "R1 reset outputs",
        int'({rdValid, wrValid, done}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(rdValid == 1'b0, "R1 idle without start", int'(rdValid), 0);
    // Walk 1: three layers, mid-run start pulse
    prog(0, 0); prog(1, 0); prog(2, 0); prog(3, 1); prog(4, 1); prog(5, 2);
    readyMode = 1; latMax = 5;
    runWalk(5, 1'b1);
    chk(sawOverlap == 1'b1, "R10 same-layer overlap", int'(sawOverlap), 1);
    // Walk 2: one layer, long result latency, restart from done
    for (int i = 0; i < 4; i++) prog(i, 3);
    readyMode = 0; latMax = 20;
    runWalk(3, 1'b0);
    chk(sawOverlap == 1'b1, "R10 issue without waiting", int'(sawOverlap), 1);
    // Walk 3: every row a new layer, sparse ready
    for (int i = 0; i < 8; i++) prog(i, (i * 5) % 16);
    readyMode = 2; latMax = 7;
    runWalk(7, 1'b1);
    // Walk 4: full table depth
    for (int i = 0; i < DEPTH; i++) prog(i, i / 4);
    readyMode = 1; latMax = 9;
    runWalk(DEPTH - 1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule